// File: doc/BRIEF.md
# Buffer Unit Tag Pool Allocator

This block manages a shared packet buffer that is split into fixed-size buffering units, each named by a small tag. It holds every unused tag in a free pool. The reassembly side takes a tag from the pool whenever a packet in progress needs another unit. The upper-layer side hands back the tags of a packet once it has finished with that packet. The pool is a first-in first-out queue, so tags are reused in the order in which they came back.

The block also drives the write port of the buffer memory. A tag and a word offset become a physical address: the tag is shifted left by log2 of the unit size and the offset fills the low bits. The units of one packet form a linked list. The last word of every unit is kept for a link, which holds the tag of the next unit. The last unit of a packet holds the null tag, which is all ones. Because the link sits inside the data, a reader can walk a packet from start to end without random access. Each command names the unit it works on, so reassemblies of several packets may be interleaved freely.

A two-state controller runs the block. After reset it is in ST_INIT and loads one tag into the pool per cycle, from 0 up to NUM_UNITS-1. After the last load it moves to ST_RUN (transition INIT_DONE) and stays there until the next reset. Reset is the only way back to ST_INIT. Commands are answered one cycle after they are presented, and any memory write is issued in that same cycle.

Top module: `tag_pool_alloc`

## Requirements
- R1: After reset the pool takes one tag per cycle, and pool_ready rises after exactly NUM_UNITS rising clock edges with reset released. A command presented before that gets rsp_valid=1 with rsp_ok=0 and no memory write.
- R2: Each command is answered on the edge after it is presented, with rsp_valid=1. The cmd_op encoding is 2'b00 write data, 2'b01 open, 2'b10 extend and 2'b11 close. An open with tags in the pool gives rsp_ok=1 and pops the oldest tag into rsp_tag. The tags loaded at reset come out in ascending order from 0.
- R3: An open or extend while the pool is empty gives rsp_ok=0 and rsp_tag equal to the null tag (all ones, TAG_W bits). It makes no memory write and removes nothing from the pool.
- R4: An extend on the unit cmd_tag pops a tag and returns it in rsp_tag. It writes that tag, zero-extended, into the last word of unit cmd_tag.
- R5: A close on the unit cmd_tag writes the null tag, zero-extended, into the last word of that unit. It answers rsp_ok=1.
- R6: A data write puts cmd_data at address cmd_tag*UNIT_WORDS + cmd_off. A data write whose offset is UNIT_WORDS-1 (the link word) is refused with rsp_ok=0 and no memory write.
- R7: A write, extend or close whose cmd_tag is NUM_UNITS or more (this includes the null tag) is refused with rsp_ok=0. It makes no write and leaves the pool unchanged.
- R8: Returned tags join the tail of the pool and are handed out again only after every tag that was already in the pool. A return and an allocation may happen in the same cycle. A tag returned in that cycle cannot be granted in that same cycle.
- R9: A return into a full pool, in a cycle with no allocation, is dropped and sets ret_err. ret_err then stays high until reset. A return into a full pool in the same cycle as a granted allocation is accepted without error.
- R10: A return of a tag of NUM_UNITS or more is dropped and sets ret_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Command code: write, open, extend, close |
| cmd_tag | input | TAG_W | Unit the command works on |
| cmd_off | input | OFF_W | Word offset for a data write |
| cmd_data | input | DATA_W | Data word for a data write |
| ret_valid | input | 1 | Upper layer returns a tag |
| ret_tag | input | TAG_W | Tag being returned |
| rsp_valid | output | 1 | Answer to the previous cycle's command |
| rsp_ok | output | 1 | Command was carried out |
| rsp_tag | output | TAG_W | Granted tag, or null |
| mem_we | output | 1 | Buffer memory write enable |
| mem_addr | output | ADDR_W | Buffer memory word address |
| mem_wdata | output | DATA_W | Buffer memory write data |
| pool_ready | output | 1 | Pool loaded, controller in ST_RUN |
| ret_err | output | 1 | Sticky return error |

## Verification
A wrong pointer or count in the pool shows up at the ports as a wrong or repeated tag on rsp_tag. It can also show up as a grant while the pool should be empty, or as a refusal while it should not be. These symptoms appear on the first allocation that reaches the damaged entry, which may be several allocations after the fault. The bench therefore drains the whole pool and checks every tag in order. A wrong address mapping or a wrong link value is seen on mem_addr and mem_wdata one cycle after the command. A stuck controller state is seen through pool_ready and through refused commands.

// File: rtl/tagpool_pkg.sv
package tagpool_pkg;
    typedef enum logic [1:0] {
        OP_WRITE  = 2'b00,
        OP_OPEN   = 2'b01,
        OP_EXTEND = 2'b10,
        OP_CLOSE  = 2'b11
    } pool_op_e;

    typedef enum logic {
        ST_INIT = 1'b0,
        ST_RUN  = 1'b1
    } pool_state_e;
endpackage

// File: rtl/tag_fifo.sv
module tag_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head  = slots[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full && !pop)); // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R3
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R9
endmodule

// File: rtl/unit_addr_map.sv
module unit_addr_map #(
    parameter int IDX_W = 4,
    parameter int OFF_W = 3
) (
    input  logic [IDX_W-1:0]       idx,
    input  logic [OFF_W-1:0]       off,
    output logic [IDX_W+OFF_W-1:0] addr
);
    assign addr = {idx, off};
endmodule

// File: rtl/pool_ctrl.sv
module pool_ctrl
    import tagpool_pkg::*;
#(
    parameter int NUM_UNITS = 16,
    parameter int IDX_W     = 4,
    parameter int TAG_W     = 5,
    parameter int OFF_W     = 3,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [TAG_W-1:0]  cmd_tag,
    input  logic [OFF_W-1:0]  cmd_off,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              ret_valid,
    input  logic [TAG_W-1:0]  ret_tag,
    input  logic [TAG_W-1:0]  fifo_head,
    input  logic              fifo_empty,
    input  logic              fifo_full,
    output logic              fifo_push,
    output logic [TAG_W-1:0]  fifo_push_tag,
    output logic              fifo_pop,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [OFF_W-1:0]  wr_off,
    output logic [DATA_W-1:0] wr_data,
    output logic              pool_ready,
    output logic              ret_err
);
    localparam int CNT_W = $clog2(NUM_UNITS);
    localparam logic [TAG_W-1:0] NULL_TAG = {TAG_W{1'b1}};
    localparam logic [OFF_W-1:0] LAST_OFF = {OFF_W{1'b1}};

    pool_state_e       state, state_nx;
    logic [CNT_W-1:0]  init_cnt;
    logic              grant, alloc_op, need_write, err_set, tag_in_range;
    logic [OFF_W-1:0]  off_sel;
    logic [DATA_W-1:0] data_sel;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_INIT;
            init_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_INIT) init_cnt <= init_cnt + 1'b1;
        end
    end

    // next state and decode
    always_comb begin
        state_nx      = state;
        fifo_push     = 1'b0;
        fifo_push_tag = '0;
        fifo_pop      = 1'b0;
        grant         = 1'b0;
        alloc_op      = 1'b0;
        need_write    = 1'b0;
        off_sel       = LAST_OFF;
        data_sel      = '0;
        err_set       = 1'b0;
        tag_in_range  = (cmd_tag < TAG_W'(NUM_UNITS));
        unique case (state)
            ST_INIT: begin
                fifo_push     = 1'b1;
                fifo_push_tag = TAG_W'(init_cnt);
                if (init_cnt == CNT_W'(NUM_UNITS - 1)) state_nx = ST_RUN;
            end
            ST_RUN: begin
                unique case (pool_op_e'(cmd_op))
                    OP_OPEN: begin
                        alloc_op = 1'b1;
                        grant    = !fifo_empty;
                    end
                    OP_EXTEND: begin
                        alloc_op   = 1'b1;
                        need_write = 1'b1;
                        grant      = !fifo_empty && tag_in_range;
                        data_sel   = DATA_W'(fifo_head);
                    end
                    OP_CLOSE: begin
                        need_write = 1'b1;
                        grant      = tag_in_range;
                        data_sel   = DATA_W'(NULL_TAG);
                    end
                    OP_WRITE: begin
                        need_write = 1'b1;
                        off_sel    = cmd_off;
                        grant      = tag_in_range && (cmd_off != LAST_OFF);
                        data_sel   = cmd_data;
                    end
                    default: grant = 1'b0;
                endcase
                fifo_pop = cmd_valid && grant && alloc_op;
                if (ret_valid) begin
                    if ((ret_tag >= TAG_W'(NUM_UNITS)) || (fifo_full && !fifo_pop)) begin
                        err_set = 1'b1;
                    end else begin
                        fifo_push     = 1'b1;
                        fifo_push_tag = ret_tag;
                    end
                end
            end
            default: state_nx = ST_INIT;
        endcase
    end

    assign pool_ready = (state == ST_RUN);

    // registered response and memory port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_tag   <= NULL_TAG;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_off    <= '0;
            wr_data   <= '0;
            ret_err   <= 1'b0;
        end else begin
            rsp_valid <= cmd_valid;
            rsp_ok    <= cmd_valid && grant;
            rsp_tag   <= (cmd_valid && grant && alloc_op) ? fifo_head : NULL_TAG;
            wr_en     <= cmd_valid && grant && need_write;
            wr_idx    <= cmd_tag[IDX_W-1:0];
            wr_off    <= off_sel;
            wr_data   <= data_sel;
            ret_err   <= ret_err || err_set;
        end
    end

    AST_INIT_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INIT) |=> !rsp_ok); // R1
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ret_err |=> ret_err); // R9
    AST_HEAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_empty |-> (fifo_head < TAG_W'(NUM_UNITS))); // R10
    AST_NULL_NOT_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> (rsp_tag == NULL_TAG)); // R3
endmodule

// File: rtl/tag_pool_alloc.sv
module tag_pool_alloc #(
    parameter int NUM_UNITS  = 16,
    parameter int UNIT_WORDS = 8,
    parameter int DATA_W     = 16,
    localparam int IDX_W     = $clog2(NUM_UNITS),
    localparam int TAG_W     = IDX_W + 1,
    localparam int OFF_W     = $clog2(UNIT_WORDS),
    localparam int ADDR_W    = IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [TAG_W-1:0]  cmd_tag,
    input  logic [OFF_W-1:0]  cmd_off,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              ret_valid,
    input  logic [TAG_W-1:0]  ret_tag,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              pool_ready,
    output logic              ret_err
);
    logic             fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [TAG_W-1:0] fifo_push_tag, fifo_head;
    logic [IDX_W-1:0] wr_idx;
    logic [OFF_W-1:0] wr_off;

    tag_fifo #(.DEPTH(NUM_UNITS), .W(TAG_W)) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (fifo_push_tag),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    pool_ctrl #(
        .NUM_UNITS (NUM_UNITS),
        .IDX_W     (IDX_W),
        .TAG_W     (TAG_W),
        .OFF_W     (OFF_W),
        .DATA_W    (DATA_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_op        (cmd_op),
        .cmd_tag       (cmd_tag),
        .cmd_off       (cmd_off),
        .cmd_data      (cmd_data),
        .ret_valid     (ret_valid),
        .ret_tag       (ret_tag),
        .fifo_head     (fifo_head),
        .fifo_empty    (fifo_empty),
        .fifo_full     (fifo_full),
        .fifo_push     (fifo_push),
        .fifo_push_tag (fifo_push_tag),
        .fifo_pop      (fifo_pop),
        .rsp_valid     (rsp_valid),
        .rsp_ok        (rsp_ok),
        .rsp_tag       (rsp_tag),
        .wr_en         (mem_we),
        .wr_idx        (wr_idx),
        .wr_off        (wr_off),
        .wr_data       (mem_wdata),
        .pool_ready    (pool_ready),
        .ret_err       (ret_err)
    );

    unit_addr_map #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_map (
        .idx  (wr_idx),
        .off  (wr_off),
        .addr (mem_addr)
    );

    AST_LINK_WORD_TAG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (mem_addr[OFF_W-1:0] == {OFF_W{1'b1}})) |->
        ((mem_wdata >> TAG_W) == '0)); // R4
    AST_WRITE_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (rsp_valid && rsp_ok)); // R6
endmodule

// File: tb/tag_pool_alloc_test.sv
module tag_pool_alloc_test;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_UNITS  = 16;
    localparam int UNIT_WORDS = 8;
    localparam int DATA_W     = 16;
    localparam int TAG_W      = 5;
    localparam int OFF_W      = 3;
    localparam int ADDR_W     = 7;
    localparam int NULL_TAG   = 31;
    localparam logic [1:0] C_WRITE = 2'b00, C_OPEN = 2'b01, C_EXT = 2'b10, C_CLOSE = 2'b11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = '0;
    logic [TAG_W-1:0]  cmd_tag = '0;
    logic [OFF_W-1:0]  cmd_off = '0;
    logic [DATA_W-1:0] cmd_data = '0;
    logic              ret_valid = 1'b0;
    logic [TAG_W-1:0]  ret_tag = '0;
    logic              rsp_valid, rsp_ok, mem_we, pool_ready, ret_err;
    logic [TAG_W-1:0]  rsp_tag;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;

    int checks = 0;
    int fails  = 0;

    tag_pool_alloc #(.NUM_UNITS(NUM_UNITS), .UNIT_WORDS(UNIT_WORDS), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_tag(cmd_tag), .cmd_off(cmd_off), .cmd_data(cmd_data),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .rsp_valid(rsp_valid),
        .rsp_ok(rsp_ok), .rsp_tag(rsp_tag), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .pool_ready(pool_ready), .ret_err(ret_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // one command and/or return, sampled just after the edge that registers it
    task automatic step(input bit cv, input logic [1:0] op, input int tag, input int off,
                        input int data, input bit rv, input int rtag);
        @(negedge clk);
        cmd_valid = cv;
        cmd_op    = op;
        cmd_tag   = TAG_W'(tag);
        cmd_off   = OFF_W'(off);
        cmd_data  = DATA_W'(data);
        ret_valid = rv;
        ret_tag   = TAG_W'(rtag);
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        ret_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        ret_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic wait_ready();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (NUM_UNITS) @(posedge clk);
        #1;
        chk("R1", "pool_ready after load", 32'(pool_ready), 1);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1", "rsp_valid in reset", 32'(rsp_valid), 0);
        chk("R1", "mem_we in reset", 32'(mem_we), 0);
        chk("R9", "ret_err in reset", 32'(ret_err), 0);
        chk("R1", "pool_ready in reset", 32'(pool_ready), 0);
    endtask

    task automatic t_init();
        @(negedge clk);
        rst_n = 1'b1;
        cmd_valid = 1'b1;
        cmd_op = C_OPEN;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        chk("R1", "rsp_valid during load", 32'(rsp_valid), 1);
        chk("R1", "rsp_ok during load", 32'(rsp_ok), 0);
        chk("R1", "mem_we during load", 32'(mem_we), 0);
        repeat (NUM_UNITS - 2) @(posedge clk);
        #1;
        chk("R1", "pool_ready one edge early", 32'(pool_ready), 0);
        @(posedge clk);
        #1;
        chk("R1", "pool_ready on time", 32'(pool_ready), 1);
    endtask

    task automatic t_open();
        for (int i = 0; i < 3; i++) begin
            step(1, C_OPEN, 0, 0, 0, 0, 0);
            chk("R2", "open rsp_valid", 32'(rsp_valid), 1);
            chk("R2", "open rsp_ok", 32'(rsp_ok), 1);
            chk("R2", "open tag order", 32'(rsp_tag), i);
            chk("R2", "open no write", 32'(mem_we), 0);
        end
    endtask

    task automatic t_write();
        step(1, C_WRITE, 2, 3, 16'hBEEF, 0, 0);
        chk("R6", "write ok", 32'(rsp_ok), 1);
        chk("R6", "write we", 32'(mem_we), 1);
        chk("R6", "write addr", 32'(mem_addr), 2 * UNIT_WORDS + 3);
        chk("R6", "write data", 32'(mem_wdata), 16'hBEEF);
        step(1, C_WRITE, 2, UNIT_WORDS - 1, 16'h1234, 0, 0);
        chk("R6", "link word write refused", 32'(rsp_ok), 0);
        chk("R6", "link word no we", 32'(mem_we), 0);
    endtask

    task automatic t_extend_close();
        step(1, C_EXT, 2, 0, 0, 0, 0);
        chk("R4", "extend ok", 32'(rsp_ok), 1);
        chk("R4", "extend new tag", 32'(rsp_tag), 3);
        chk("R4", "extend we", 32'(mem_we), 1);
        chk("R4", "extend link addr", 32'(mem_addr), 2 * UNIT_WORDS + 7);
        chk("R4", "extend link data", 32'(mem_wdata), 3);
        step(1, C_CLOSE, 3, 0, 0, 0, 0);
        chk("R5", "close ok", 32'(rsp_ok), 1);
        chk("R5", "close we", 32'(mem_we), 1);
        chk("R5", "close addr", 32'(mem_addr), 3 * UNIT_WORDS + 7);
        chk("R5", "close null link", 32'(mem_wdata), NULL_TAG);
    endtask

    task automatic t_bad_tag();
        step(1, C_CLOSE, NULL_TAG, 0, 0, 0, 0);
        chk("R7", "close null tag refused", 32'(rsp_ok), 0);
        chk("R7", "close null tag no we", 32'(mem_we), 0);
        step(1, C_EXT, 16, 0, 0, 0, 0);
        chk("R7", "extend bad tag refused", 32'(rsp_ok), 0);
        chk("R7", "extend bad tag no we", 32'(mem_we), 0);
        step(1, C_WRITE, 20, 1, 5, 0, 0);
        chk("R7", "write bad tag no we", 32'(mem_we), 0);
        step(1, C_OPEN, 0, 0, 0, 0, 0);
        chk("R7", "pool untouched by refusals", 32'(rsp_tag), 4);
    endtask

    task automatic t_return_order();
        int exp_seq [13] = '{5, 6, 7, 8, 9, 10, 11, 12, 13, 14, 15, 1, 0};
        step(0, C_OPEN, 0, 0, 0, 1, 1);
        step(0, C_OPEN, 0, 0, 0, 1, 0);
        chk("R9", "legal returns no error", 32'(ret_err), 0);
        for (int i = 0; i < 13; i++) begin
            step(1, C_OPEN, 0, 0, 0, 0, 0);
            chk("R8", "drain order", 32'(rsp_tag), exp_seq[i]);
        end
        step(1, C_OPEN, 0, 0, 0, 0, 0);
        chk("R3", "open on empty refused", 32'(rsp_ok), 0);
        chk("R3", "open on empty null tag", 32'(rsp_tag), NULL_TAG);
        step(1, C_EXT, 0, 0, 0, 0, 0);
        chk("R3", "extend on empty refused", 32'(rsp_ok), 0);
        chk("R3", "extend on empty no we", 32'(mem_we), 0);
    endtask

    task automatic t_empty_swap();
        step(1, C_OPEN, 0, 0, 0, 1, 7);
        chk("R8", "no bypass when empty", 32'(rsp_ok), 0);
        step(1, C_OPEN, 0, 0, 0, 1, 9);
        chk("R8", "pop with push", 32'(rsp_tag), 7);
        step(1, C_OPEN, 0, 0, 0, 0, 0);
        chk("R8", "pushed tag follows", 32'(rsp_tag), 9);
        chk("R9", "no error after swaps", 32'(ret_err), 0);
    endtask

    task automatic t_ret_range();
        step(0, C_OPEN, 0, 0, 0, 1, 20);
        chk("R10", "out of range return flags", 32'(ret_err), 1);
        step(0, C_OPEN, 0, 0, 0, 0, 0);
        chk("R9", "error sticky", 32'(ret_err), 1);
        step(1, C_OPEN, 0, 0, 0, 0, 0);
        chk("R10", "bad tag not pooled", 32'(rsp_ok), 0);
    endtask

    task automatic t_full_pool();
        do_reset();
        wait_ready();
        step(1, C_OPEN, 0, 0, 0, 1, 5);
        chk("R9", "full pool pop+push grant", 32'(rsp_tag), 0);
        chk("R9", "full pool pop+push no error", 32'(ret_err), 0);
        step(0, C_OPEN, 0, 0, 0, 1, 6);
        chk("R9", "overflow flags", 32'(ret_err), 1);
        step(0, C_OPEN, 0, 0, 0, 0, 0);
        chk("R9", "overflow sticky", 32'(ret_err), 1);
        for (int i = 1; i < NUM_UNITS; i++) begin
            step(1, C_OPEN, 0, 0, 0, 0, 0);
        end
        step(1, C_OPEN, 0, 0, 0, 0, 0);
        chk("R9", "accepted tag at tail", 32'(rsp_tag), 5);
        step(1, C_OPEN, 0, 0, 0, 0, 0);
        chk("R9", "dropped tag absent", 32'(rsp_ok), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_init();
        t_open();
        t_write();
        t_extend_close();
        t_bad_tag();
        t_return_order();
        t_empty_swap();
        t_ret_range();
        t_full_pool();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule